// File: doc/BRIEF.md
# Signed-Count Shift and Integer-to-Float Unit

This block is the shift stage of a 32-bit compute datapath. A single 8-bit two's-complement count selects both the distance and the direction of a shift. Positive values move bits toward the most significant end, and negative values move them toward the least significant end. The unit can shift arithmetically, shift logically, or convert a signed 32-bit integer to an IEEE-754 single-precision pattern. In the conversion, the same count is used as a power-of-two scale, so a shift and an integer-to-float conversion are done in one operation.

Each operation is presented with a one-cycle valid strobe. The result is registered and appears on the cycle after the strobe, together with a valid pulse and a zero flag. Between operations the output register keeps its last value.

Top module: `shc_unit`

## Requirements
- R1: With operation code 2'b00 or 2'b01 and a count of 0 to 127, the operand shifts left by the count. Vacated low bits are filled with zeros, and a count of 32 or more gives all zeros.
- R2: With operation code 2'b00 (arithmetic) and a negative count -m, the operand shifts right by m with the sign bit copied into the vacated high bits. The result equals floor(operand / 2^m); for example, -2 divides by four. When m is 32 or more, every bit equals the operand's sign bit.
- R3: With operation code 2'b01 (logical) and a negative count -m, the operand shifts right by m with zeros filling the high bits. When m is 32 or more, the result is zero.
- R4: A count of zero in either shift operation returns the operand unchanged.
- R5: Operation code 2'b10 converts with scaling by the count. Operation code 2'b11 converts with no scaling, and the count has no effect on the result.
- R6: Conversion treats the operand as a signed 32-bit integer. It returns the IEEE single-precision pattern (sign bit 31, biased exponent bits 30:23 with bias 127, fraction bits 22:0), rounded to nearest with ties to even.
- R7: A scaled conversion with count n returns the float value of operand × 2^n, rounded as in R6.
- R8: A zero operand converts to 32'h0000_0000. A result whose biased exponent after rounding would be 0 or less is flushed to 32'h0000_0000; no subnormal pattern is ever produced.
- R9: A conversion whose biased exponent after rounding would be 255 or more returns a signed infinity: the sign bit, exponent 8'hFF and fraction zero.
- R10: The zero flag is high exactly when all 32 result bits are zero.
- R11: The result and zero flag appear one cycle after the valid strobe, with the output valid high for exactly that cycle. Without a strobe, the result and zero flag hold their values.
- R12: During reset, the output valid is low, the result is zero and the zero flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 2 | Operation code: 00 arithmetic shift, 01 logical shift, 10 scaled convert, 11 plain convert |
| in_operand | input | 32 | Integer operand |
| in_count | input | 8 | Two's-complement shift count or conversion scale |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_result | output | 32 | Registered result |
| out_zero | output | 1 | Registered all-zero flag of the result |

## Verification
The datapath has no state apart from the output register. A wrong direction decode, fill bit or rounding choice therefore shows up in the result on the very cycle after the offending strobe. The bench sweeps all 256 counts across a set of sign-edge and carry-edge operands for each operation, so a wrong saturation threshold or fill shows at the first count that crosses it. Rounding faults appear on the tie and just-above-tie operands, and exponent faults appear at the edges of the scale range where the result flushes or overflows. A register that fails to hold, or a valid that fails to pulse, is seen on the idle cycles that follow a vector.

// File: rtl/shc_pkg.sv
// Package: shared widths, float format constants and operation codes
// for the signed-count shift and conversion unit.
package shc_pkg;
    localparam int WORD_W = 32;                 // operand and result width
    localparam int CNT_W  = 8;                  // signed count width
    localparam int SH_W   = $clog2(WORD_W);     // in-range shift amount bits
    localparam int EXP_W  = 8;                  // float exponent field
    localparam int MAN_W  = 23;                 // float fraction field
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_MAX = (1 << EXP_W) - 1;  // all-ones exponent
    localparam int BE_W   = CNT_W + 3;          // width of exponent arithmetic

    typedef enum logic [1:0] {
        OP_ASH    = 2'b00,
        OP_LSH    = 2'b01,
        OP_CVT_SC = 2'b10,
        OP_CVT    = 2'b11
    } shc_op_e;
endpackage

// File: rtl/shc_barrel.sv
// Module: shc_barrel
// Shifts a word by a signed count. It assumes a two's-complement count in
// which a negative value means a right shift. Left shifts reuse the
// right-shift stages by bit-reversing the word before and after them.
// A magnitude of WORD_W or more saturates to all-fill.
module shc_barrel
    import shc_pkg::*;
(
    input  logic [WORD_W-1:0] data_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              arith_i,
    output logic [WORD_W-1:0] data_o
);
    localparam int MAG_W = CNT_W;

    logic              go_right;
    logic [MAG_W-1:0]  mag;
    logic              too_far;
    logic [SH_W-1:0]   amt;
    logic              fill;
    logic [WORD_W-1:0] staged_in;
    logic [WORD_W-1:0] stage [SH_W+1];
    logic [WORD_W-1:0] shifted;

    // Split the signed count into a direction and a magnitude.
    always_comb begin
        go_right = count_i[CNT_W-1];
        mag      = go_right ? (~count_i + 1'b1) : count_i;
        too_far  = (mag >= MAG_W'(WORD_W));
        amt      = mag[SH_W-1:0];
        fill     = go_right & arith_i & data_i[WORD_W-1];
    end

    // Put the word in right-shift orientation (reverse it for a left shift).
    always_comb begin
        for (int i = 0; i < WORD_W; i++) begin
            staged_in[i] = go_right ? data_i[i] : data_i[WORD_W-1-i];
        end
    end

    assign stage[0] = staged_in;

    // One logarithmic right-shift stage per amount bit.
    generate
        for (genvar k = 0; k < SH_W; k++) begin : g_stage
            localparam int DIST = 1 << k;
            assign stage[k+1] = amt[k]
                ? {{DIST{fill}}, stage[k][WORD_W-1:DIST]}
                : stage[k];
        end
    endgenerate

    // Restore the orientation and apply the out-of-range saturation.
    always_comb begin
        for (int i = 0; i < WORD_W; i++) begin
            shifted[i] = go_right ? stage[SH_W][i] : stage[SH_W][WORD_W-1-i];
        end
        data_o = too_far ? {WORD_W{fill}} : shifted;
    end
endmodule

// File: rtl/shc_int2flt.sv
// Module: shc_int2flt
// Converts a signed integer to single precision, scaled by 2^scale.
// It assumes no subnormal output. Rounding is to nearest even. A result
// that would underflow flushes to +0, and one that would overflow becomes
// a signed infinity.
module shc_int2flt
    import shc_pkg::*;
(
    input  logic [WORD_W-1:0] int_i,
    input  logic [CNT_W-1:0]  scale_i,
    output logic [WORD_W-1:0] flt_o
);
    localparam int GRD = WORD_W - 2 - MAN_W;    // guard bit index in norm

    logic              sgn;
    logic [WORD_W-1:0] mag;
    logic [SH_W-1:0]   lead;
    logic [SH_W-1:0]   lzc;
    logic [WORD_W-1:0] norm;
    logic [MAN_W-1:0]  frac;
    logic              guard;
    logic              sticky;
    logic              rnd_up;
    logic [MAN_W:0]    frac_r;
    logic              carry;
    logic [BE_W-1:0]   be;
    logic signed [BE_W-1:0] be_s;

    // Take the sign and the magnitude of the integer.
    always_comb begin
        sgn = int_i[WORD_W-1];
        mag = sgn ? (~int_i + 1'b1) : int_i;
    end

    // Find the position of the leading one.
    always_comb begin
        lead = '0;
        for (int i = 0; i < WORD_W; i++) begin
            if (mag[i]) lead = SH_W'(i);
        end
        lzc = SH_W'(WORD_W - 1) - lead;
    end

    // Normalize and gather the rounding bits.
    always_comb begin
        norm   = mag << lzc;
        frac   = norm[WORD_W-2 -: MAN_W];
        guard  = norm[GRD];
        sticky = |norm[GRD-1:0];
        rnd_up = guard & (sticky | frac[0]);
        frac_r = {1'b0, frac} + (MAN_W+1)'(rnd_up);
        carry  = frac_r[MAN_W];
    end

    // Form the biased exponent, including the scale and the rounding carry.
    always_comb begin
        be   = BE_W'(lead) + {{(BE_W-CNT_W){scale_i[CNT_W-1]}}, scale_i}
             + BE_W'(BIAS) + BE_W'(carry);
        be_s = $signed(be);
    end

    // Pack the result, or select zero, the flush or infinity.
    always_comb begin
        if (mag == '0 || be_s <= 0) begin
            flt_o = '0;
        end else if (be_s >= BE_W'(EXP_MAX)) begin
            flt_o = {sgn, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
        end else begin
            flt_o = {sgn, be[EXP_W-1:0], frac_r[MAN_W-1:0]};
        end
    end

    // R8: a zero exponent field must never carry a fraction (no subnormals).
    always_comb begin
        p_no_denorm_r8: assert (!((flt_o[WORD_W-2 -: EXP_W] == '0) &&
                                  (flt_o[MAN_W-1:0] != '0)))
            else $error("subnormal pattern produced");
    end
endmodule

// File: rtl/shc_unit.sv
// Module: shc_unit (top)
// Decodes the operation, routes the operand through the barrel shifter or
// the converter, and registers the result, the zero flag and valid.
// It assumes a one-cycle strobe per operation. The output holds between
// operations.
module shc_unit
    import shc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_op,
    input  logic [WORD_W-1:0] in_operand,
    input  logic [CNT_W-1:0]  in_count,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_result,
    output logic              out_zero
);
    shc_op_e           op;
    logic              is_cvt;
    logic [CNT_W-1:0]  scale;
    logic [WORD_W-1:0] sh_res;
    logic [WORD_W-1:0] cv_res;
    logic [WORD_W-1:0] nxt;

    // Decode the operation code into unit selects and the scale.
    always_comb begin
        op     = shc_op_e'(in_op);
        is_cvt = (op == OP_CVT_SC) || (op == OP_CVT);
        scale  = (op == OP_CVT_SC) ? in_count : '0;
    end

    shc_barrel u_barrel (
        .data_i  (in_operand),
        .count_i (in_count),
        .arith_i (op == OP_ASH),
        .data_o  (sh_res)
    );

    shc_int2flt u_cvt (
        .int_i   (in_operand),
        .scale_i (scale),
        .flt_o   (cv_res)
    );

    // Choose the result of the selected unit.
    always_comb nxt = is_cvt ? cv_res : sh_res;

    // Output register: reset, capture on a strobe, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_zero   <= 1'b1;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result <= nxt;
                out_zero   <= (nxt == '0);
            end
        end
    end

    // R11: a strobe produces valid on the next cycle.
    p_valid_next_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R11: no strobe means no valid on the next cycle, and the result holds.
    p_valid_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_zero)));
    // R10: the flag agrees with the registered result.
    p_zero_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_zero == (out_result == '0));
    // R1: a left shift of 32 or more leaves nothing.
    p_left_far_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_op[1] && !in_count[CNT_W-1] &&
         (in_count >= CNT_W'(WORD_W))) |=> (out_result == '0));
    // R2: an arithmetic right shift of 32 or more gives all sign bits.
    p_sign_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'b00 && ($signed(in_count) <= -WORD_W))
        |=> (out_result == {WORD_W{$past(in_operand[WORD_W-1])}}));
    // R3: a logical right shift of 32 or more gives zero.
    p_lsr_far_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'b01 && ($signed(in_count) <= -WORD_W))
        |=> (out_result == '0));
    // R8: a zero integer converts to +0.
    p_zero_cvt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op[1] && in_operand == '0) |=> (out_result == '0));
endmodule

// File: tb/shc_unit_test.sv
`timescale 1ns/1ps
module shc_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_op = 2'b00;
    logic [31:0] in_operand = '0;
    logic [7:0]  in_count = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_zero;

    int nvec = 0;
    int nfail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    shc_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_operand(in_operand), .in_count(in_count),
        .out_valid(out_valid), .out_result(out_result), .out_zero(out_zero)
    );

    // Shift reference, computed with integer arithmetic.
    function automatic logic [31:0] ref_shift(input logic arith,
                                              input logic [31:0] a,
                                              input logic [7:0] c);
        int n = $signed(c);
        longint v, d, q;
        if (n >= 0) begin
            if (n >= 32) return 32'h0;
            v = longint'(a) * (longint'(1) << n);
            return v[31:0];
        end
        if (-n >= 40) d = longint'(1) << 40; else d = longint'(1) << (-n);
        if (arith) begin
            v = longint'($signed(a));
            q = v / d;
            if (v < 0 && (v % d) != 0) q = q - 1;
        end else begin
            v = longint'(a);
            q = v / d;
        end
        return q[31:0];
    endfunction

    // Conversion reference: exact magnitude, remainder rounding.
    function automatic logic [31:0] ref_conv(input logic [31:0] a,
                                             input int sc);
        longint v, mag, q, rem, half;
        int p, sh, be;
        logic s;
        v = longint'($signed(a));
        if (v == 0) return 32'h0;
        s = (v < 0);
        mag = s ? -v : v;
        p = 0;
        for (int i = 0; i < 33; i++) if (((mag >> i) & 1) != 0) p = i;
        if (p > 23) begin
            sh = p - 23;
            q = mag >> sh;
            rem = mag & ((longint'(1) << sh) - 1);
            half = longint'(1) << (sh - 1);
            if (rem > half || (rem == half && q[0])) q = q + 1;
            if (q == (longint'(1) << 24)) begin
                q = q >> 1;
                p = p + 1;
            end
        end else begin
            q = mag << (23 - p);
        end
        be = p + sc + 127;
        if (be <= 0) return 32'h0;
        if (be >= 255) return {s, 8'hFF, 23'h0};
        return {s, be[7:0], q[22:0]};
    endfunction

    task automatic apply(input logic [1:0] op, input logic [31:0] a,
                         input logic [7:0] c, input logic [31:0] exp,
                         input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_operand = a; in_count = c;
        @(negedge clk);
        in_valid = 1'b0;
        nvec++;
        if (out_result !== exp || out_valid !== 1'b1) begin
            nfail++;
            $display("FAIL %s op=%b a=%h c=%0d: result=%h valid=%b expected %h valid=1",
                     tag, op, a, $signed(c), out_result, out_valid, exp);
        end else if (out_zero !== (exp == 32'h0)) begin
            nfail++;
            $display("FAIL R10 op=%b a=%h c=%0d: zero=%b expected %b",
                     op, a, $signed(c), out_zero, (exp == 32'h0));
        end
    endtask

    function automatic string shift_tag(input logic [1:0] op, input int n);
        if (n > 0) return "R1";
        if (n == 0) return "R4";
        return (op == 2'b00) ? "R2" : "R3";
    endfunction

    function automatic string conv_tag(input logic [1:0] op, input int n,
                                       input logic [31:0] e);
        if (e == 32'h0) return "R8";
        if (e[30:23] == 8'hFF) return "R9";
        if (op == 2'b11 && n != 0) return "R5";
        if (op == 2'b10 && n != 0) return "R7";
        return "R6";
    endfunction

    logic [31:0] sh_ops [9] = '{32'h0000_0006, 32'hFFFF_FFFA, 32'h8000_0000,
                                32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0001,
                                32'hA5C3_0F96, 32'h0000_0000, 32'h4000_0001};
    logic [31:0] cv_ops [12] = '{32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0006,
                                 32'h0100_0001, 32'h0100_0003, 32'h8000_0000,
                                 32'h7FFF_FFFF, 32'h0000_0000, 32'h00FF_FFFF,
                                 32'hFEFF_FFFF, 32'h0000_0019, 32'h1234_5678};

    // Watchdog: an expired run counts as a failed check.
    initial begin
        #1_000_000;
        if (!finished) begin
            nfail++;
            nvec++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        logic [31:0] e;
        // R12: state during reset
        repeat (3) @(negedge clk);
        nvec++;
        if (out_valid !== 1'b0 || out_result !== 32'h0 || out_zero !== 1'b1) begin
            nfail++;
            $display("FAIL R12 reset: valid=%b result=%h zero=%b expected 0 00000000 1",
                     out_valid, out_result, out_zero);
        end
        rst_n = 1'b1;

        // Hand-picked corner vectors
        apply(2'b00, 32'h0000_0006, 8'hFE, 32'h0000_0001, "R2");
        apply(2'b00, 32'hFFFF_FFFA, 8'hFE, 32'hFFFF_FFFE, "R2");
        apply(2'b01, 32'h8000_0000, 8'hE1, 32'h0000_0001, "R3");
        apply(2'b00, 32'h8000_0000, 8'h80, 32'hFFFF_FFFF, "R2");
        apply(2'b01, 32'h0000_0001, 8'h1F, 32'h8000_0000, "R1");
        apply(2'b11, 32'h0000_0001, 8'h00, 32'h3F80_0000, "R6");
        apply(2'b11, 32'hFFFF_FFFF, 8'h05, 32'hBF80_0000, "R5");
        apply(2'b10, 32'h0000_0006, 8'hFE, 32'h3FC0_0000, "R7");
        apply(2'b11, 32'h0100_0001, 8'h00, 32'h4B80_0000, "R6");
        apply(2'b11, 32'h0100_0003, 8'h00, 32'h4B80_0002, "R6");
        apply(2'b11, 32'h8000_0000, 8'h00, 32'hCF00_0000, "R6");
        apply(2'b10, 32'h0000_0001, 8'h7F, 32'h7F00_0000, "R9");
        apply(2'b10, 32'h0000_0002, 8'h7F, 32'h7F80_0000, "R9");
        apply(2'b10, 32'hFFFF_FFFE, 8'h7F, 32'hFF80_0000, "R9");
        apply(2'b10, 32'h0000_0001, 8'h82, 32'h0080_0000, "R8");
        apply(2'b10, 32'h0000_0001, 8'h81, 32'h0000_0000, "R8");
        apply(2'b10, 32'h0000_0000, 8'h10, 32'h0000_0000, "R8");

        // R11: idle cycles keep the result and drop valid
        held = out_result;
        repeat (2) @(negedge clk);
        nvec++;
        if (out_valid !== 1'b0 || out_result !== held) begin
            nfail++;
            $display("FAIL R11 idle: valid=%b result=%h expected 0 %h",
                     out_valid, out_result, held);
        end

        // Shift sweep: every count, both shift kinds
        for (int k = 0; k < 9; k++) begin
            for (int c = 0; c < 256; c++) begin
                for (int o = 0; o < 2; o++) begin
                    e = ref_shift(o == 0, sh_ops[k], c[7:0]);
                    apply(o[1:0], sh_ops[k], c[7:0], e,
                          shift_tag(o[1:0], $signed(c[7:0])));
                end
            end
        end

        // Conversion sweep: every scale, plus the count-ignored form
        for (int k = 0; k < 12; k++) begin
            for (int c = 0; c < 256; c++) begin
                e = ref_conv(cv_ops[k], $signed(c[7:0]));
                apply(2'b10, cv_ops[k], c[7:0], e,
                      conv_tag(2'b10, $signed(c[7:0]), e));
            end
            for (int c = 0; c < 256; c += 37) begin
                e = ref_conv(cv_ops[k], 0);
                apply(2'b11, cv_ops[k], c[7:0], e,
                      conv_tag(2'b11, $signed(c[7:0]), e));
            end
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule